// File: doc/BRIEF.md
# Link power supervisor for a PHY-to-link interface

This block sits on the physical-layer side of a PHY-to-link interface. It watches the power-status line that the link-layer controller drives and chooses the state of the interface from it. A low pulse shorter than a first timeout is treated as noise. When the line stays low past that timeout, the interface drops into a low-power reset state. In that state the control and data lines going to the link are forced low and link requests are dropped, while the interface clock keeps running. When the line stays low past a second, longer timeout, the interface goes into a low-power disabled state and the interface clock enable is also removed.

As soon as the status line is sampled high again, the interface returns to normal operation, and the block issues a one-cycle initialise strobe. If the interface is coming back from the disabled state it reached by timeout, the block also issues a one-cycle bus-reset request. That bus reset lets the node announce that its link is reachable again. A hardware reset places the interface in the disabled state. Leaving that particular disabled state gives an initialise strobe but no bus reset. No register bit takes part in these decisions; only the status line does.

The status line is assumed to be already synchronised to `clk`. Both timeouts are counted in `clk` cycles.

Top module: `link_pwr_supervisor`

## Requirements
- R1: The status input counts as inactive only after it has been sampled low on more than `RST_TO` consecutive rising edges, which means at least `RST_TO`+1 edges. The state leaves normal on the edge that follows. A single high sample restarts the count, so a low stretch of `RST_TO` edges or fewer changes nothing.
- R2: Outside the normal state, `ctl_o` and `dat_o` are all zeros and `req_fwd_o` is 0 whatever `link_req_i` does.
- R3: In the low-power reset state `clk_en_o` stays 1.
- R4: When the low count exceeds `DIS_TO` (entry on the edge after `DIS_TO`+1 low samples), the interface enters the disabled state. There `clk_en_o` is 0 and the outputs stay quiet as in R2.
- R5: From the reset or the disabled state, the first rising edge that samples the status input high returns the interface to normal. `if_init_o` is 1 for exactly the first cycle of normal operation.
- R6: While `rst_n` is low (synchronous), the interface is in the disabled state with `clk_en_o` = 0, and it stays there while the status input is low. Leaving it gives `if_init_o` but no `bus_rst_req_o`.
- R7: `bus_rst_req_o` is a one-cycle pulse, coincident with `if_init_o`. It occurs only when leaving a disabled state that was entered by the `DIS_TO` timeout, never when leaving the reset state.
- R8: In the normal state, `ctl_o`, `dat_o` and `req_fwd_o` follow `core_ctl_i`, `core_dat_i` and `link_req_i` in the same cycle.
- R9: `clk_en_o` comes straight from a flip-flop, so it changes only at a rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing is counted in it |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| link_stat_i | input | 1 | Power-status line from the link layer, already synchronised |
| link_req_i | input | 1 | Request line from the link layer |
| core_ctl_i | input | CTL_W | Control value from the PHY core toward the link |
| core_dat_i | input | DAT_W | Data value from the PHY core toward the link |
| ctl_o | output | CTL_W | Gated control lines to the link |
| dat_o | output | DAT_W | Gated data lines to the link |
| req_fwd_o | output | 1 | Link request passed to the PHY core, blocked outside normal |
| clk_en_o | output | 1 | Registered enable for the interface clock gate |
| if_init_o | output | 1 | One-cycle strobe on return to normal |
| bus_rst_req_o | output | 1 | One-cycle bus-reset request after a timed-out disable |

## Verification
If the low-duration counter is off by one, the move into the reset or disabled state shifts by one cycle. The ports show this as quiet outputs or a dropped clock enable exactly one edge early or late. If the state register or its transition logic is wrong, the result appears within one edge of the status line changing: outputs that fail to pass through, a clock enable that drops in the reset state, or a missing initialise strobe. If the flag recording how the disabled state was entered is wrong, the result appears only on the single return edge, as a bus-reset pulse after a hardware reset or no pulse after a timed-out disable. The bench therefore samples one cycle before and one cycle after every boundary.

// File: rtl/lpwr_pkg.sv
// Package lpwr_pkg
// Shared types for the link power supervisor.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package lpwr_pkg;

    // Interface state. Only IF_NORM lets traffic through.
    typedef enum logic [1:0] {
        IF_NORM  = 2'd0,
        IF_LPRST = 2'd1,
        IF_LPDIS = 2'd2
    } if_state_e;

endpackage

// File: rtl/lpwr_low_timer.sv
// Module lpwr_low_timer
// Counts consecutive low samples of the status line and flags when the count
// is past the reset timeout and past the disable timeout.
// Assumes: stat_i is synchronous to clk; DIS_TO > RST_TO.
module lpwr_low_timer #(
    parameter int RST_TO = 8,
    parameter int DIS_TO = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_i,
    output logic over_rst_o,
    output logic over_dis_o
);
    localparam int CW = $clog2(DIS_TO + 2);
    localparam logic [CW-1:0] SAT   = CW'(DIS_TO + 1);
    localparam logic [CW-1:0] RLIM  = CW'(RST_TO);
    localparam logic [CW-1:0] DLIM  = CW'(DIS_TO);

    logic [CW-1:0] cnt_q;

    // Low-run counter: cleared by any high sample, saturates above DIS_TO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (stat_i) begin
            cnt_q <= '0;
        end else if (cnt_q != SAT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Threshold decode of the registered count.
    always_comb begin
        over_rst_o = (cnt_q > RLIM);
        over_dis_o = (cnt_q > DLIM);
    end

    // R1: a high sample restarts the measurement.
    a_r1_clear_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        stat_i |=> (cnt_q == '0));

    // R1: each low sample below saturation adds exactly one.
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_i && cnt_q != SAT) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R4: passing the disable limit implies passing the reset limit.
    a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
        over_dis_o |-> over_rst_o);

endmodule

// File: rtl/lpwr_state_ctl.sv
// Module lpwr_state_ctl
// Interface state machine. Moves between normal, low-power reset and
// low-power disabled from the status line and the timer flags, and produces
// the registered clock enable, initialise strobe and bus-reset request.
// Assumes: over_dis_i is never set without over_rst_i; synchronous reset.
module lpwr_state_ctl
    import lpwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stat_i,
    input  logic      over_rst_i,
    input  logic      over_dis_i,
    output if_state_e state_o,
    output logic      clk_en_o,
    output logic      init_o,
    output logic      busrst_o
);
    if_state_e state_q, state_nxt;
    logic      dis_by_to_q, dis_by_to_nxt;
    logic      leaving;
    logic      clk_en_q, init_q, busrst_q;

    // Next-state decode from the status line and the timer flags.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            IF_NORM: begin
                if (over_dis_i)      state_nxt = IF_LPDIS;
                else if (over_rst_i) state_nxt = IF_LPRST;
            end
            IF_LPRST: begin
                if (stat_i)          state_nxt = IF_NORM;
                else if (over_dis_i) state_nxt = IF_LPDIS;
            end
            IF_LPDIS: begin
                if (stat_i)          state_nxt = IF_NORM;
            end
            default:                 state_nxt = IF_LPDIS;
        endcase
    end

    // Return detection and the record of how the disabled state was entered.
    always_comb begin
        leaving       = (state_q != IF_NORM) && (state_nxt == IF_NORM);
        dis_by_to_nxt = dis_by_to_q;
        if (state_q != IF_LPDIS && state_nxt == IF_LPDIS) begin
            dis_by_to_nxt = 1'b1;
        end else if (leaving) begin
            dis_by_to_nxt = 1'b0;
        end
    end

    // State and entry-record registers; hardware reset parks in disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= IF_LPDIS;
            dis_by_to_q <= 1'b0;
        end else begin
            state_q     <= state_nxt;
            dis_by_to_q <= dis_by_to_nxt;
        end
    end

    // Registered outputs: clock enable and the two one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en_q <= 1'b0;
            init_q   <= 1'b0;
            busrst_q <= 1'b0;
        end else begin
            clk_en_q <= (state_nxt != IF_LPDIS);
            init_q   <= leaving;
            busrst_q <= leaving && (state_q == IF_LPDIS) && dis_by_to_q;
        end
    end

    assign state_o  = state_q;
    assign clk_en_o = clk_en_q;
    assign init_o   = init_q;
    assign busrst_o = busrst_q;

    // R1: a short low run keeps the interface in normal.
    a_r1_hold_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IF_NORM && !over_rst_i) |=> (state_q == IF_NORM));

    // R3: clock keeps running in the reset state.
    a_r3_clk_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IF_LPRST) |-> clk_en_o);

    // R4: clock held off in the disabled state.
    a_r4_clk_off_dis: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IF_LPDIS) |-> !clk_en_o);

    // R5: a high sample outside normal returns with an init strobe.
    a_r5_leave_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != IF_NORM && stat_i) |=> (state_q == IF_NORM && init_o));

    // R5: the init strobe lasts one cycle.
    a_r5_init_single: assert property (@(posedge clk) disable iff (!rst_n)
        init_o |=> !init_o);

    // R7: bus reset only together with init and after the disabled state.
    a_r7_busrst_with_init: assert property (@(posedge clk) disable iff (!rst_n)
        busrst_o |-> (init_o && $past(state_q) == IF_LPDIS));

endmodule

// File: rtl/lpwr_port_gate.sv
// Module lpwr_port_gate
// Gates the control and data lines toward the link and the request toward
// the core: pass-through in normal, forced low otherwise.
// Assumes: pass_i is a clean registered-state decode.
module lpwr_port_gate #(
    parameter int CTL_W = 2,
    parameter int DAT_W = 8
) (
    input  logic             pass_i,
    input  logic [CTL_W-1:0] ctl_i,
    input  logic [DAT_W-1:0] dat_i,
    input  logic             req_i,
    output logic [CTL_W-1:0] ctl_o,
    output logic [DAT_W-1:0] dat_o,
    output logic             req_o
);
    // AND-gate every line with the pass condition.
    always_comb begin
        ctl_o = ctl_i & {CTL_W{pass_i}};
        dat_o = dat_i & {DAT_W{pass_i}};
        req_o = req_i & pass_i;
    end

endmodule

// File: rtl/link_pwr_supervisor.sv
// Module link_pwr_supervisor (top)
// Supervises the link power-status line and sets the PHY-to-link interface
// state: normal, low-power reset (lines low, clock running) or low-power
// disabled (lines low, clock enable off). Strobes init on return and
// requests a bus reset after a timed-out disable.
// Assumes: link_stat_i synchronised to clk; DIS_TO > RST_TO >= 1.
module link_pwr_supervisor
    import lpwr_pkg::*;
#(
    parameter int RST_TO = 8,
    parameter int DIS_TO = 24,
    parameter int CTL_W  = 2,
    parameter int DAT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_stat_i,
    input  logic             link_req_i,
    input  logic [CTL_W-1:0] core_ctl_i,
    input  logic [DAT_W-1:0] core_dat_i,
    output logic [CTL_W-1:0] ctl_o,
    output logic [DAT_W-1:0] dat_o,
    output logic             req_fwd_o,
    output logic             clk_en_o,
    output logic             if_init_o,
    output logic             bus_rst_req_o
);
    logic      over_rst, over_dis;
    if_state_e if_state;
    logic      pass;

    // Low-duration measurement.
    lpwr_low_timer #(.RST_TO(RST_TO), .DIS_TO(DIS_TO)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_i     (link_stat_i),
        .over_rst_o (over_rst),
        .over_dis_o (over_dis)
    );

    // Interface state and strobes.
    lpwr_state_ctl u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_i     (link_stat_i),
        .over_rst_i (over_rst),
        .over_dis_i (over_dis),
        .state_o    (if_state),
        .clk_en_o   (clk_en_o),
        .init_o     (if_init_o),
        .busrst_o   (bus_rst_req_o)
    );

    assign pass = (if_state == IF_NORM);

    // Line gating.
    lpwr_port_gate #(.CTL_W(CTL_W), .DAT_W(DAT_W)) u_gate (
        .pass_i (pass),
        .ctl_i  (core_ctl_i),
        .dat_i  (core_dat_i),
        .req_i  (link_req_i),
        .ctl_o  (ctl_o),
        .dat_o  (dat_o),
        .req_o  (req_fwd_o)
    );

    // R2: lines quiet and request dropped whenever the clock enable is off.
    a_r2_quiet_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en_o |-> (ctl_o == '0 && dat_o == '0 && !req_fwd_o));

    // R9: clock enable only falls after the disable limit was crossed.
    a_r9_clk_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en_o) |-> $past(over_dis));

    initial begin
        a_r4_param_order: assert (DIS_TO > RST_TO && RST_TO >= 1);
    end

endmodule

// File: tb/tb_link_pwr_supervisor.sv
// Directed bench for link_pwr_supervisor: one task per scenario.
module tb_link_pwr_supervisor;
    localparam int RST_TO = 8;
    localparam int DIS_TO = 24;
    localparam int CTL_W  = 2;
    localparam int DAT_W  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             link_stat_i = 1'b0;
    logic             link_req_i = 1'b0;
    logic [CTL_W-1:0] core_ctl_i = '0;
    logic [DAT_W-1:0] core_dat_i = '0;
    logic [CTL_W-1:0] ctl_o;
    logic [DAT_W-1:0] dat_o;
    logic             req_fwd_o, clk_en_o, if_init_o, bus_rst_req_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    link_pwr_supervisor #(.RST_TO(RST_TO), .DIS_TO(DIS_TO),
                          .CTL_W(CTL_W), .DAT_W(DAT_W)) dut (
        .clk(clk), .rst_n(rst_n), .link_stat_i(link_stat_i),
        .link_req_i(link_req_i), .core_ctl_i(core_ctl_i),
        .core_dat_i(core_dat_i), .ctl_o(ctl_o), .dat_o(dat_o),
        .req_fwd_o(req_fwd_o), .clk_en_o(clk_en_o), .if_init_o(if_init_o),
        .bus_rst_req_o(bus_rst_req_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One rising edge passes; inputs change and outputs are read at negedge.
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_quiet(input string tag);
        chk({tag, " ctl"}, 32'(ctl_o), 0);
        chk({tag, " dat"}, 32'(dat_o), 0);
        chk({tag, " req"}, 32'(req_fwd_o), 0);
    endtask

    task automatic chk_pass(input string tag);
        chk({tag, " ctl"}, 32'(ctl_o), 32'(core_ctl_i));
        chk({tag, " dat"}, 32'(dat_o), 32'(core_dat_i));
        chk({tag, " req"}, 32'(req_fwd_o), 32'(link_req_i));
    endtask

    // R6: hardware reset parks in disabled; first return has no bus reset.
    task automatic t_hw_reset();
        rst_n = 1'b0; link_stat_i = 1'b0; link_req_i = 1'b1;
        core_ctl_i = 2'b11; core_dat_i = 8'hA5;
        tick(3);
        chk("R6 reset clk_en", 32'(clk_en_o), 0);
        chk_quiet("R6 reset");
        rst_n = 1'b1;
        tick(DIS_TO + 5);
        chk("R6 stays disabled clk_en", 32'(clk_en_o), 0);
        chk_quiet("R6 stays disabled");
        link_stat_i = 1'b1;
        tick(1);
        chk("R6 init on return", 32'(if_init_o), 1);
        chk("R6 no bus reset", 32'(bus_rst_req_o), 0);
        chk("R6 clk_en back", 32'(clk_en_o), 1);
        tick(1);
        chk("R5 init single", 32'(if_init_o), 0);
    endtask

    // R8: pass-through in normal for several patterns.
    task automatic t_pass();
        for (int i = 0; i < 4; i++) begin
            core_ctl_i = CTL_W'(i);
            core_dat_i = DAT_W'(8'h3C ^ (i * 37));
            link_req_i = i[0];
            tick(1);
            chk_pass("R8 pass");
        end
    endtask

    // R1: low runs of RST_TO edges never leave normal.
    task automatic t_glitch();
        link_req_i = 1'b1; core_dat_i = 8'h5A;
        for (int k = 0; k < 3; k++) begin
            link_stat_i = 1'b0;
            tick(RST_TO);
            link_stat_i = 1'b1;
            tick(1);
            chk_pass("R1 short low");
            chk("R1 no init", 32'(if_init_o), 0);
        end
    endtask

    // R1/R2/R3/R5/R7: enter reset state exactly, then return.
    task automatic t_lp_reset();
        link_req_i = 1'b1; core_ctl_i = 2'b10; core_dat_i = 8'hC3;
        link_stat_i = 1'b0;
        tick(RST_TO + 1);
        chk_pass("R1 edge before inactive");
        tick(1);
        chk_quiet("R2 reset state");
        chk("R3 clk runs", 32'(clk_en_o), 1);
        tick(3);
        chk("R3 clk still runs", 32'(clk_en_o), 1);
        chk_quiet("R2 reset state later");
        link_stat_i = 1'b1;
        tick(1);
        chk("R5 init from reset", 32'(if_init_o), 1);
        chk("R7 no bus reset from reset", 32'(bus_rst_req_o), 0);
        chk_pass("R5 normal again");
        tick(1);
        chk("R5 init single", 32'(if_init_o), 0);
    endtask

    // R4/R7/R9: timed-out disable and the bus reset on return.
    task automatic t_lp_disable();
        link_req_i = 1'b1; core_ctl_i = 2'b01; core_dat_i = 8'h7E;
        link_stat_i = 1'b0;
        tick(DIS_TO + 1);
        chk("R4 edge before disable clk_en", 32'(clk_en_o), 1);
        tick(1);
        chk("R4 disabled clk_en", 32'(clk_en_o), 0);
        chk_quiet("R4 disabled");
        tick(6);
        chk("R9 clk_en held off", 32'(clk_en_o), 0);
        link_stat_i = 1'b1;
        tick(1);
        chk("R7 bus reset", 32'(bus_rst_req_o), 1);
        chk("R5 init from disable", 32'(if_init_o), 1);
        chk("R4 clk_en back", 32'(clk_en_o), 1);
        chk_pass("R8 after disable");
        tick(1);
        chk("R7 bus reset single", 32'(bus_rst_req_o), 0);
        chk("R5 init single", 32'(if_init_o), 0);
    endtask

    // R6/R7: hardware reset after a timed-out disable clears the record.
    task automatic t_reset_clears();
        link_stat_i = 1'b0;
        tick(DIS_TO + 3);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1; link_stat_i = 1'b1;
        tick(1);
        chk("R6 init after reset", 32'(if_init_o), 1);
        chk("R7 no bus reset after hw reset", 32'(bus_rst_req_o), 0);
    endtask

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(1);
        t_hw_reset();
        t_pass();
        t_glitch();
        t_lp_reset();
        t_lp_disable();
        t_pass();
        t_reset_clears();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule